// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block lays a 32x32 two-colour cursor over a raster scan-out stream. Software programs it through a small register window. Each of the 32 cursor rows has a transparency word and a colour-select word. One register holds the cursor position, and one is a general-purpose control word. During scan-out the display pipeline presents the current pixel coordinates and the palette index of the underlying pixel. One clock later the block returns either that index or one of two overlay palette indices, 258 or 259. The palette lookup that turns those indices into RGB sits downstream.

Position, transparency and colour-select writes land in a pending copy. The displayed copy is refreshed from the pending copy only on a frame-start pulse, so a frame never shows a half-updated cursor. Each write to a cursor register also raises a one-cycle strobe with two line ranges. A display refresh engine uses these ranges to redraw only the affected lines.

Top module: `curov_top`

## Requirements
- R1: After synchronous reset, the pending and displayed position are both X=0xF000 and Y=0xF000, all row words are zero, the control word is zero, reg_rdata is zero and inval_vld is low. Every pixel therefore passes through unchanged.
- R2: A write with reg_addr 0x8FC sets the pending X from reg_wdata[31:16] and the pending Y from reg_wdata[15:0].
- R3: A write with reg_addr 0x900+4*r (r = 0..31) sets the pending transparency word of row r. A write with reg_addr 0x980+4*r sets the pending colour-select word of row r.
- R4: In a cursor row, bit 31 of a word covers column X and bit 31-c covers column X+c. Where the transparency bit is 0, pix_in passes. Where it is 1, the output is 259 if the colour-select bit is 1 and 258 if it is 0.
- R5: The overlay applies only to lines pix_y with Y <= pix_y <= Y+31. Row index is pix_y-Y.
- R6: The overlay applies only if X < SCR_W and pix_x < SCR_W. It covers at most 32 columns, so at the right edge only SCR_W-X columns show.
- R7: reg_rdata is registered and reflects the reg_addr of the previous cycle. Offset 0x818 returns the stored control word with bit 25 forced to 1. Every other offset returns zero. A write to 0x818 stores reg_wdata.
- R8: A write to the position, transparency or colour-select registers raises inval_vld for exactly the next cycle. A write to any other offset does not raise it. Range A is [Y, min(Y+32, SCR_H)) for the pending Y before the write. Range B is the same formula for the new Y on a position write, and equals range A otherwise. If Y >= SCR_H, the range is reported as lo = hi = SCR_H.
- R9: pix_out depends on pix_x, pix_y and pix_in sampled one clock earlier, with the same one-cycle latency on the overlay and pass-through paths.
- R10: Pending changes do not affect pix_out until a frame_start pulse copies the pending position and row words into the displayed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset in the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous address |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pix_x | input | 16 | Current scan-out column |
| pix_y | input | 16 | Current scan-out line |
| pix_in | input | IDXW | Palette index of the underlying pixel |
| pix_out | output | IDXW | Palette index after cursor overlay |
| inval_vld | output | 1 | Redraw strobe |
| inval_a_lo | output | 16 | Range A first line |
| inval_a_hi | output | 16 | Range A end line (exclusive) |
| inval_b_lo | output | 16 | Range B first line |
| inval_b_hi | output | 16 | Range B end line (exclusive) |

## Verification
The pixel-path properties assume that the coordinates and pix_in are ordinary inputs that may change every cycle. They compare pix_out only against pix_in from the previous cycle, in cases where the cursor cannot cover the pixel. The range properties assume SCR_H is small enough that Y+32 fits in 17 bits. The bench shrinks the screen to 64x48 and sweeps every pixel on it for several cursor positions, including positions past the right edge and below the last line. It drives register writes only on word-aligned offsets and issues frame_start only between sweeps, so the bench's model of the displayed set changes exactly where the design's does.

// File: rtl/curov_pkg.sv
package curov_pkg;
  localparam int unsigned CUR_N = 32;
  localparam logic [11:0] OFF_MISC  = 12'h818;
  localparam logic [11:0] OFF_POS   = 12'h8FC;
  localparam logic [4:0]  MASK_PAGE = 5'h12;
  localparam logic [4:0]  IMG_PAGE  = 5'h13;
  localparam logic [15:0] PARK_POS  = 16'hF000;
  localparam logic [31:0] MISC_FORCE = 32'h0200_0000;
  localparam int unsigned IDX_CLR0 = 258;
  localparam int unsigned IDX_CLR1 = 259;

  typedef enum logic [2:0] {A_NONE, A_MISC, A_POS, A_MASK, A_IMG} acc_e;

  function automatic acc_e decode_acc(input logic [11:0] a);
    if (a == OFF_MISC) return A_MISC;
    if (a == OFF_POS) return A_POS;
    if (a[11:7] == MASK_PAGE && a[1:0] == 2'b00) return A_MASK;
    if (a[11:7] == IMG_PAGE && a[1:0] == 2'b00) return A_IMG;
    return A_NONE;
  endfunction
endpackage

// File: rtl/curov_span.sv
module curov_span #(
  parameter int unsigned SCR_H = 768
) (
  input  logic [15:0] y,
  output logic [15:0] lo,
  output logic [15:0] hi
);
  localparam logic [16:0] H17 = 17'(SCR_H);
  logic [16:0] y_end;

  always_comb begin
    y_end = {1'b0, y} + 17'd32;
    if ({1'b0, y} >= H17) begin
      lo = H17[15:0];
      hi = H17[15:0];
    end else begin
      lo = y;
      hi = (y_end > H17) ? H17[15:0] : y_end[15:0];
    end
  end
endmodule

// File: rtl/curov_regs.sv
module curov_regs
  import curov_pkg::*;
#(
  parameter int unsigned SCR_H = 768
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [11:0]            reg_addr,
  input  logic [31:0]            reg_wdata,
  input  logic                   frame_start,
  output logic [31:0]            reg_rdata,
  output logic                   inval_vld,
  output logic [15:0]            inval_a_lo,
  output logic [15:0]            inval_a_hi,
  output logic [15:0]            inval_b_lo,
  output logic [15:0]            inval_b_hi,
  output logic [15:0]            act_x,
  output logic [15:0]            act_y,
  output logic [CUR_N-1:0][31:0] act_mask,
  output logic [CUR_N-1:0][31:0] act_img
);
  localparam int unsigned ROW_W = $clog2(CUR_N);

  acc_e                   acc;
  logic                   cur_hit;
  logic [ROW_W-1:0]       row_sel;
  logic [15:0]            sh_x, sh_y, misc_q;
  logic [31:0]            misc_word;
  logic [CUR_N-1:0][31:0] sh_mask, sh_img;
  logic [15:0]            span_y  [2];
  logic [15:0]            span_lo [2];
  logic [15:0]            span_hi [2];

  assign acc     = decode_acc(reg_addr);
  assign cur_hit = (acc == A_POS) || (acc == A_MASK) || (acc == A_IMG);
  assign row_sel = reg_addr[ROW_W+1:2];

  // pending copy, written by software
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_x      <= PARK_POS;
      sh_y      <= PARK_POS;
      sh_mask   <= '0;
      sh_img    <= '0;
      misc_word <= '0;
    end else if (reg_we) begin
      unique case (acc)
        A_POS:  begin sh_x <= reg_wdata[31:16]; sh_y <= reg_wdata[15:0]; end
        A_MASK: sh_mask[row_sel] <= reg_wdata;
        A_IMG:  sh_img[row_sel]  <= reg_wdata;
        A_MISC: misc_word <= reg_wdata;
        default: ;
      endcase
    end
  end

  // displayed copy, refreshed only at frame start
  always_ff @(posedge clk) begin
    if (rst) begin
      act_x    <= PARK_POS;
      act_y    <= PARK_POS;
      act_mask <= '0;
      act_img  <= '0;
    end else if (frame_start) begin
      act_x    <= sh_x;
      act_y    <= sh_y;
      act_mask <= sh_mask;
      act_img  <= sh_img;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= (acc == A_MISC) ? (misc_word | MISC_FORCE) : '0;
  end

  // span 0: location before the write; span 1: location after it
  assign span_y[0] = sh_y;
  assign span_y[1] = (acc == A_POS) ? reg_wdata[15:0] : sh_y;

  for (genvar g = 0; g < 2; g++) begin : g_span
    curov_span #(.SCR_H(SCR_H)) u_span (
      .y  (span_y[g]),
      .lo (span_lo[g]),
      .hi (span_hi[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inval_vld  <= 1'b0;
      inval_a_lo <= '0;
      inval_a_hi <= '0;
      inval_b_lo <= '0;
      inval_b_hi <= '0;
    end else begin
      inval_vld <= reg_we && cur_hit;
      if (reg_we && cur_hit) begin
        inval_a_lo <= span_lo[0];
        inval_a_hi <= span_hi[0];
        inval_b_lo <= span_lo[1];
        inval_b_hi <= span_hi[1];
      end
    end
  end

  assign misc_q = misc_word[15:0];

  p_strobe_on_write_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_we && cur_hit) |=> inval_vld);
  p_no_strobe_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && cur_hit) |=> !inval_vld);
  p_range_bound_r8: assert property (@(posedge clk) disable iff (rst)
    inval_vld |-> (inval_a_lo <= inval_a_hi) && (32'(inval_a_hi) <= SCR_H)
                  && (inval_a_hi - inval_a_lo <= 16'd32)
                  && (inval_b_lo <= inval_b_hi) && (32'(inval_b_hi) <= SCR_H));
  p_misc_bit25_r7: assert property (@(posedge clk) disable iff (rst)
    (acc == A_MISC) |=> reg_rdata[25]);
  p_misc_low_r7: assert property (@(posedge clk) disable iff (rst)
    (acc == A_MISC) |=> reg_rdata[15:0] == $past(misc_q));
  p_other_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (acc != A_MISC) |=> reg_rdata == '0);
  p_frame_only_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act_x) && $stable(act_y) && $stable(act_mask));
endmodule

// File: rtl/curov_pix.sv
module curov_pix
  import curov_pkg::*;
#(
  parameter int unsigned SCR_W = 1024,
  parameter int unsigned IDXW  = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            pix_x,
  input  logic [15:0]            pix_y,
  input  logic [IDXW-1:0]        pix_in,
  input  logic [15:0]            act_x,
  input  logic [15:0]            act_y,
  input  logic [CUR_N-1:0][31:0] act_mask,
  input  logic [CUR_N-1:0][31:0] act_img,
  output logic [IDXW-1:0]        pix_out
);
  localparam logic [16:0]     W17  = 17'(SCR_W);
  localparam logic [IDXW-1:0] CLR0 = IDXW'(IDX_CLR0);
  localparam logic [IDXW-1:0] CLR1 = IDXW'(IDX_CLR1);

  logic [16:0] dy, dx;
  logic        in_y, in_x, vis, m_bit, i_bit, hit;
  logic [4:0]  row, col;

  always_comb begin
    dy    = {1'b0, pix_y} - {1'b0, act_y};
    dx    = {1'b0, pix_x} - {1'b0, act_x};
    in_y  = (pix_y >= act_y) && (dy[16:5] == '0);
    in_x  = (pix_x >= act_x) && (dx[16:5] == '0);
    vis   = ({1'b0, act_x} < W17) && ({1'b0, pix_x} < W17);
    row   = dy[4:0];
    col   = dx[4:0];
    // column c of the cursor lives at bit 31-c, i.e. bit ~c
    m_bit = act_mask[row][~col];
    i_bit = act_img[row][~col];
    hit   = in_y && in_x && vis && m_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)      pix_out <= '0;
    else if (hit) pix_out <= i_bit ? CLR1 : CLR0;
    else          pix_out <= pix_in;
  end

  p_pass_above_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_y < act_y) |=> pix_out == $past(pix_in));
  p_pass_right_r6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, pix_x} >= W17) |=> pix_out == $past(pix_in));
  p_pass_off_x_r6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, act_x} >= W17) |=> pix_out == $past(pix_in));
  p_overlay_code_r4: assert property (@(posedge clk) disable iff (rst)
    (hit) |=> (pix_out == CLR0) || (pix_out == CLR1));
endmodule

// File: rtl/curov_top.sv
module curov_top
  import curov_pkg::*;
#(
  parameter int unsigned SCR_W = 1024,
  parameter int unsigned SCR_H = 768,
  parameter int unsigned IDXW  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [11:0]     reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            frame_start,
  input  logic [15:0]     pix_x,
  input  logic [15:0]     pix_y,
  input  logic [IDXW-1:0] pix_in,
  output logic [IDXW-1:0] pix_out,
  output logic            inval_vld,
  output logic [15:0]     inval_a_lo,
  output logic [15:0]     inval_a_hi,
  output logic [15:0]     inval_b_lo,
  output logic [15:0]     inval_b_hi
);
  logic [15:0]            act_x, act_y;
  logic [CUR_N-1:0][31:0] act_mask, act_img;

  curov_regs #(.SCR_H(SCR_H)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .frame_start (frame_start),
    .reg_rdata   (reg_rdata),
    .inval_vld   (inval_vld),
    .inval_a_lo  (inval_a_lo),
    .inval_a_hi  (inval_a_hi),
    .inval_b_lo  (inval_b_lo),
    .inval_b_hi  (inval_b_hi),
    .act_x       (act_x),
    .act_y       (act_y),
    .act_mask    (act_mask),
    .act_img     (act_img)
  );

  curov_pix #(.SCR_W(SCR_W), .IDXW(IDXW)) u_pix (
    .clk      (clk),
    .rst      (rst),
    .pix_x    (pix_x),
    .pix_y    (pix_y),
    .pix_in   (pix_in),
    .act_x    (act_x),
    .act_y    (act_y),
    .act_mask (act_mask),
    .act_img  (act_img),
    .pix_out  (pix_out)
  );
endmodule

// File: tb/curov_top_tb.sv
`timescale 1ns/1ps
module curov_top_tb;
  localparam int W = 64;
  localparam int H = 48;
  localparam int IDXW = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [11:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            frame_start = 1'b0;
  logic [15:0]     pix_x = '0, pix_y = '0;
  logic [IDXW-1:0] pix_in = '0;
  logic [IDXW-1:0] pix_out;
  logic            inval_vld;
  logic [15:0]     inval_a_lo, inval_a_hi, inval_b_lo, inval_b_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model: pending (s*) and displayed (a*)
  logic [31:0] s_mask [32], s_img [32], a_mask [32], a_img [32];
  int sx = 'hF000, sy = 'hF000, ax = 'hF000, ay = 'hF000;

  always #2.5 clk = ~clk;

  curov_top #(.SCR_W(W), .SCR_H(H), .IDXW(IDXW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in), .pix_out(pix_out),
    .inval_vld(inval_vld), .inval_a_lo(inval_a_lo), .inval_a_hi(inval_a_hi),
    .inval_b_lo(inval_b_lo), .inval_b_hi(inval_b_hi)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int span_lo(input int y);
    return (y >= H) ? H : y;
  endfunction
  function automatic int span_hi(input int y);
    if (y >= H) return H;
    return (y + 32 > H) ? H : y + 32;
  endfunction

  function automatic int model_pix(input int x, input int y, input int pin);
    int r, c;
    if (y >= ay && y < ay + 32 && ax < W && x >= ax && x < ax + 32 && x < W) begin
      r = y - ay;
      c = x - ax;
      if (a_mask[r][31-c]) return a_img[r][31-c] ? 259 : 258;
    end
    return pin;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // write a cursor register and check the redraw strobe of the next cycle
  task automatic wr_cur(input logic [11:0] a, input logic [31:0] d);
    int alo, ahi, blo, bhi;
    alo = span_lo(sy); ahi = span_hi(sy);
    if (a == 12'h8FC) begin
      blo = span_lo(int'(d[15:0])); bhi = span_hi(int'(d[15:0]));
      sx = int'(d[31:16]); sy = int'(d[15:0]);
    end else begin
      blo = alo; bhi = ahi;
      if (a[7]) s_img[a[6:2]] = d; else s_mask[a[6:2]] = d;
    end
    wr(a, d);
    chk("R8 strobe", 32'(inval_vld), 32'd1);
    chk("R8 a_lo", 32'(inval_a_lo), 32'(alo));
    chk("R8 a_hi", 32'(inval_a_hi), 32'(ahi));
    chk("R8 b_lo", 32'(inval_b_lo), 32'(blo));
    chk("R8 b_hi", 32'(inval_b_hi), 32'(bhi));
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    ax = sx; ay = sy;
    for (int r = 0; r < 32; r++) begin a_mask[r] = s_mask[r]; a_img[r] = s_img[r]; end
  endtask

  // full-screen sweep, pix_out compared one cycle after each pixel (R9)
  task automatic sweep(input string tag);
    int exp_q;
    bit have;
    have = 1'b0;
    exp_q = 0;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        if (have) chk(tag, 32'(pix_out), 32'(exp_q));
        pix_x = 16'(x); pix_y = 16'(y); pix_in = IDXW'((x * 5 + y * 3) & 255);
        exp_q = model_pix(x, y, int'(pix_in));
        have = 1'b1;
      end
    end
    @(negedge clk);
    chk(tag, 32'(pix_out), 32'(exp_q));
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] m, im;
    for (int r = 0; r < 32; r++) begin
      s_mask[r] = '0; s_img[r] = '0; a_mask[r] = '0; a_img[r] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'd0);
    chk("R1 strobe", 32'(inval_vld), 32'd0);
    sweep("R1 parked");

    // R3: fill every row; parked Y gives empty ranges (R8)
    for (int r = 0; r < 32; r++) begin
      m  = (r == 0) ? 32'hFFFF_FFFF : ((32'hF0F0_C3A5 >> r) ^ (32'(r) * 32'h0101_0101));
      im = (r == 0) ? 32'h8000_0000 : (~m ^ (32'(r) * 32'h1357_0000));
      wr_cur(12'h900 + 12'(4 * r), m);
      wr_cur(12'h980 + 12'(4 * r), im);
    end
    wr_cur(12'h8FC, {16'd20, 16'd10});   // R2
    sweep("R10 pending hidden");
    frame();
    sweep("R4 R5 R9 mid");

    // R4: leftmost column of row 0 uses bit 31
    @(negedge clk);
    pix_x = 16'd20; pix_y = 16'd10; pix_in = 9'd7;
    @(negedge clk);
    chk("R4 bit31", 32'(pix_out), 32'd259);
    pix_x = 16'd21;
    @(negedge clk);
    chk("R4 bit30", 32'(pix_out), 32'd258);

    wr_cur(12'h8FC, {16'd50, 16'd30});
    frame();
    sweep("R6 right clip");
    wr_cur(12'h90C, 32'hAAAA_5555);
    wr_cur(12'h8FC, {16'd64, 16'd0});
    frame();
    sweep("R6 x at width");
    wr_cur(12'h8FC, {16'd63, 16'd47});
    frame();
    sweep("R5 R6 corner");
    wr_cur(12'h8FC, {16'd0, 16'd100});
    frame();
    sweep("R5 below screen");
    wr_cur(12'h8FC, {16'd0, 16'd0});
    frame();
    sweep("R2 R3 origin");

    // R7 control word and read-zero offsets; R8 no strobe on it
    wr(12'h818, 32'h4100_00AB);
    chk("R8 misc no strobe", 32'(inval_vld), 32'd0);
    rd(12'h818, 32'h4300_00AB, "R7 misc");
    rd(12'h8FC, 32'd0, "R7 pos reads zero");
    rd(12'h900, 32'd0, "R7 mask reads zero");
    wr(12'h818, 32'h0200_0001);
    rd(12'h818, 32'h0200_0001, "R7 misc bit25 set");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule